// File: doc/BRIEF.md
# Shadow-RAM Configuration and Status Register File

This block is the register file a processor uses to set up and observe one peripheral. It has two kinds of register. Configuration words are written by the processor and read by the peripheral. Status words are written by the peripheral and only read by the processor.

Each configuration word lives in two places. The first is a bank of flip-flops that drives the peripheral directly. The second is a copy in a single-port RAM. Every processor write to a configuration address updates both copies in the same cycle. A processor read of a configuration address is answered from the RAM copy, so the configuration range needs no wide readback multiplexer. Only the few status words, which the peripheral can change at any time, keep a conventional registered multiplexer.

The address map has two ranges. The configuration range starts at address 0 and is dense. The status range follows it directly. Every address above the status range is unmapped. Read data for every kind of address appears one cycle after the read strobe.

Before the processor has written a configuration word, the RAM copy of that word is undefined. One flag per configuration word records whether it has been written since reset. Until it has, a read of that word returns the word's reset value instead of the RAM contents. The RAM therefore needs no initialisation pass after reset.

Top module: `csr_shadow_file`

## Requirements
- R1: After reset, configuration word i (addresses 0 to N_CFG-1; output slice `cfg_q[i*DW +: DW]`) holds (0x5A00 + 0x0101*i) modulo 2^DW. A read of word i returns this value until the word is first written, and `bus_rdata` is zero.
- R2: A write (`bus_wr`=1) to configuration address a updates slice a of `cfg_q` to `bus_wdata` at the same clock edge. All other slices are unchanged.
- R3: A read (`bus_rd`=1, `bus_wr`=0) of configuration address a presents the last value written to a on `bus_rdata` after the next clock edge.
- R4: A read issued in the cycle right after a write to the same configuration address returns the newly written value.
- R5: A read of address N_CFG+k, for k from 0 to N_STAT-1, returns slice k of `stat_in` as sampled at the read edge. The result appears one cycle after the strobe.
- R6: A read of an address at or above N_CFG+N_STAT returns zero.
- R7: Writes to status or unmapped addresses leave every bit of `cfg_q` unchanged.
- R8: `bus_rdata` keeps its value in every cycle that carries no read.
- R9: When `bus_rd` and `bus_wr` are both high, only the write is performed. `bus_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid one cycle after the read strobe |
| cfg_q | output | N_CFG*DW | Flip-flop configuration words, word i at slice i |
| stat_in | input | N_STAT*DW | Peripheral status words, word k at slice k |

## Verification
The main test is a seeded random mix of reads, writes, simultaneous read-and-write and idle cycles, spread over the full address space.

- Reads of configuration words that have never been written tell the reset-value path apart from the RAM path.
- Reads that follow a write in the very next cycle show whether the RAM update and the read ordering are correct.
- Status reads are made while the status inputs keep changing, which tells a value sampled at the read edge from a stale one.
- Writes aimed at the status range and at unmapped addresses confirm that the configuration outputs stay untouched.

// File: rtl/csr_shadow_pkg.sv
package csr_shadow_pkg;

    localparam int unsigned DEF_DW     = 16;
    localparam int unsigned DEF_AW     = 6;
    localparam int unsigned DEF_NCFG   = 16;
    localparam int unsigned DEF_NSTAT  = 4;

    typedef enum logic [1:0] {
        PATH_NONE = 2'd0,
        PATH_CFG  = 2'd1,
        PATH_STAT = 2'd2
    } path_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [63:0] cfg_reset_word(input int unsigned idx);
        return 64'h5A00 + 64'h0101 * 64'(idx);
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_shadow_pkg::*;
#(
    parameter int unsigned AW     = DEF_AW,
    parameter int unsigned NCFG   = DEF_NCFG,
    parameter int unsigned NSTAT  = DEF_NSTAT,
    parameter int unsigned CIW    = idx_width(NCFG),
    parameter int unsigned SIW    = idx_width(NSTAT)
) (
    input  logic [AW-1:0]  addr,
    output path_e          path,
    output logic [CIW-1:0] cfg_idx,
    output logic [SIW-1:0] stat_idx
);
    localparam logic [AW:0] CFG_END  = (AW+1)'(NCFG);
    localparam logic [AW:0] STAT_END = (AW+1)'(NCFG + NSTAT);

    logic [AW:0] addr_x;
    assign addr_x = {1'b0, addr};

    always_comb begin
        path     = PATH_NONE;
        cfg_idx  = '0;
        stat_idx = '0;
        if (addr_x < CFG_END) begin
            path    = PATH_CFG;
            cfg_idx = CIW'(addr);
        end else if (addr_x < STAT_END) begin
            path     = PATH_STAT;
            stat_idx = SIW'(addr_x - CFG_END);
        end
    end
endmodule

// File: rtl/csr_shadow_ram.sv
module csr_shadow_ram #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned IW    = 4
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [IW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/csr_cfg_regs.sv
module csr_cfg_regs
    import csr_shadow_pkg::*;
#(
    parameter int unsigned DW   = DEF_DW,
    parameter int unsigned NCFG = DEF_NCFG,
    parameter int unsigned CIW  = idx_width(NCFG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CIW-1:0]   idx,
    input  logic [DW-1:0]    wdata,
    output logic [NCFG*DW-1:0] q,
    output logic [NCFG-1:0]  written
);
    for (genvar i = 0; i < NCFG; i++) begin : g_word
        localparam logic [63:0] RV = cfg_reset_word(i);
        logic hit;
        assign hit = we && (idx == CIW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                q[i*DW +: DW] <= RV[DW-1:0];
                written[i]    <= 1'b0;
            end else if (hit) begin
                q[i*DW +: DW] <= wdata;
                written[i]    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/csr_stat_mux.sv
module csr_stat_mux #(
    parameter int unsigned DW    = 16,
    parameter int unsigned NSTAT = 4,
    parameter int unsigned SIW   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [SIW-1:0]      idx,
    input  logic [NSTAT*DW-1:0] stat_in,
    output logic [DW-1:0]       q
);
    logic [DW-1:0] words [NSTAT];

    for (genvar k = 0; k < NSTAT; k++) begin : g_split
        assign words[k] = stat_in[k*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (rd_en) begin
            q <= words[idx];
        end
    end
endmodule

// File: rtl/csr_shadow_file.sv
module csr_shadow_file
    import csr_shadow_pkg::*;
#(
    parameter int unsigned DW    = DEF_DW,
    parameter int unsigned AW    = DEF_AW,
    parameter int unsigned NCFG  = DEF_NCFG,
    parameter int unsigned NSTAT = DEF_NSTAT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic [NCFG*DW-1:0]  cfg_q,
    input  logic [NSTAT*DW-1:0] stat_in
);
    localparam int unsigned CIW = idx_width(NCFG);
    localparam int unsigned SIW = idx_width(NSTAT);

    path_e          path;
    logic [CIW-1:0] cfg_idx;
    logic [SIW-1:0] stat_idx;
    logic           rd_go;
    logic           cfg_we;
    logic           ram_en;
    logic [DW-1:0]  ram_q;
    logic [DW-1:0]  stat_q;
    logic [NCFG-1:0] written;

    path_e          path_q;
    logic           fresh_q;
    logic [DW-1:0]  rst_word_q;
    logic [DW-1:0]  rst_tab [NCFG];

    assign rd_go  = bus_rd && !bus_wr;
    assign cfg_we = bus_wr && (path == PATH_CFG);
    assign ram_en = (rd_go || bus_wr) && (path == PATH_CFG);

    for (genvar i = 0; i < NCFG; i++) begin : g_rst_tab
        localparam logic [63:0] RV = cfg_reset_word(i);
        assign rst_tab[i] = RV[DW-1:0];
    end

    csr_addr_decode #(
        .AW(AW), .NCFG(NCFG), .NSTAT(NSTAT), .CIW(CIW), .SIW(SIW)
    ) u_dec (
        .addr     (bus_addr),
        .path     (path),
        .cfg_idx  (cfg_idx),
        .stat_idx (stat_idx)
    );

    csr_cfg_regs #(
        .DW(DW), .NCFG(NCFG), .CIW(CIW)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .wdata   (bus_wdata),
        .q       (cfg_q),
        .written (written)
    );

    csr_shadow_ram #(
        .DW(DW), .DEPTH(NCFG), .IW(CIW)
    ) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (bus_wr),
        .addr  (cfg_idx),
        .wdata (bus_wdata),
        .rdata (ram_q)
    );

    csr_stat_mux #(
        .DW(DW), .NSTAT(NSTAT), .SIW(SIW)
    ) u_stat (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_go && (path == PATH_STAT)),
        .idx     (stat_idx),
        .stat_in (stat_in),
        .q       (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q     <= PATH_NONE;
            fresh_q    <= 1'b0;
            rst_word_q <= '0;
        end else if (rd_go) begin
            path_q     <= path;
            fresh_q    <= (path == PATH_CFG) && !written[cfg_idx];
            rst_word_q <= rst_tab[cfg_idx];
        end
    end

    always_comb begin
        unique case (path_q)
            PATH_CFG:  bus_rdata = fresh_q ? rst_word_q : ram_q;
            PATH_STAT: bus_rdata = stat_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/csr_shadow_chk.sv
module csr_shadow_chk #(
    parameter int unsigned DW    = 16,
    parameter int unsigned AW    = 6,
    parameter int unsigned NCFG  = 16,
    parameter int unsigned NSTAT = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [AW-1:0]       bus_addr,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [DW-1:0]       bus_wdata,
    input logic [DW-1:0]       bus_rdata,
    input logic [NCFG*DW-1:0]  cfg_q,
    input logic [NSTAT*DW-1:0] stat_in
);
    logic          is_cfg, is_stat, is_none;
    logic          wr_cfg_q, rd_stat_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, stat_word, stat_word_q, cfg_word_now;

    assign is_cfg  = int'(bus_addr) < NCFG;
    assign is_stat = !is_cfg && (int'(bus_addr) < NCFG + NSTAT);
    assign is_none = !is_cfg && !is_stat;

    always_comb begin
        stat_word = '0;
        for (int k = 0; k < NSTAT; k++)
            if (int'(bus_addr) == NCFG + k) stat_word = stat_in[k*DW +: DW];
        cfg_word_now = '0;
        for (int i = 0; i < NCFG; i++)
            if (int'(addr_q) == i) cfg_word_now = cfg_q[i*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cfg_q    <= 1'b0;
            rd_stat_q   <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            stat_word_q <= '0;
        end else begin
            wr_cfg_q    <= bus_wr && is_cfg;
            rd_stat_q   <= bus_rd && !bus_wr && is_stat;
            addr_q      <= bus_addr;
            wdata_q     <= bus_wdata;
            stat_word_q <= stat_word;
        end
    end

    p_cfg_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_cfg_q |-> cfg_word_now == wdata_q);

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && is_cfg) |=> $stable(cfg_q));

    p_stat_read_r5: assert property (@(posedge clk) disable iff (rst)
        rd_stat_q |-> bus_rdata == stat_word_q);

    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && is_none) |=> bus_rdata == '0);

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    p_rd_wr_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr) |=> $stable(bus_rdata));
endmodule

bind csr_shadow_file csr_shadow_chk #(
    .DW(DW), .AW(AW), .NCFG(NCFG), .NSTAT(NSTAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_q     (cfg_q),
    .stat_in   (stat_in)
);

// File: tb/sim_csr_shadow_file.sv
`timescale 1ns/1ps
module sim_csr_shadow_file;
    localparam int DW = 16, AW = 6, NCFG = 16, NSTAT = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [AW-1:0]       bus_addr = '0;
    logic                bus_rd = 1'b0, bus_wr = 1'b0;
    logic [DW-1:0]       bus_wdata = '0;
    logic [DW-1:0]       bus_rdata;
    logic [NCFG*DW-1:0]  cfg_q;
    logic [NSTAT*DW-1:0] stat_in = '0;

    int checks = 0, errors = 0;
    logic [DW-1:0] model [NCFG];
    logic [DW-1:0] last_rd;

    always #2 clk = ~clk;

    csr_shadow_file u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_q(cfg_q), .stat_in(stat_in)
    );

    function automatic logic [DW-1:0] reset_val(input int i);
        return DW'(32'h5A00 + 32'h0101 * i);
    endfunction

    function automatic logic [DW-1:0] exp_read(input int a);
        if (a < NCFG) return model[a];
        if (a < NCFG + NSTAT) return stat_in[(a-NCFG)*DW +: DW];
        return '0;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_cfg(input string req);
        for (int i = 0; i < NCFG; i++) check(req, cfg_q[i*DW +: DW], model[i]);
    endtask

    // one bus cycle: drive at negedge, sample at following negedge
    task automatic cycle(input int a, input bit rd, input bit wr, input logic [DW-1:0] d);
        bus_addr = AW'(a); bus_rd = rd; bus_wr = wr; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        if (wr && a < NCFG) model[a] = d;
    endtask

    task automatic rd_check(input int a, input string req);
        logic [DW-1:0] e;
        e = exp_read(a);
        cycle(a, 1'b1, 1'b0, '0);
        check(req, bus_rdata, e);
        last_rd = bus_rdata;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NCFG; i++) model[i] = reset_val(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_cfg("R1");
        check("R1", bus_rdata, '0);
        rd_check(5, "R1");
        rd_check(NCFG-1, "R1");

        // R2, R4 write then immediate read
        cycle(3, 1'b0, 1'b1, 16'hBEEF);
        check_cfg("R2");
        rd_check(3, "R4");
        cycle(0, 1'b0, 1'b1, 16'h0001);
        rd_check(0, "R4");
        rd_check(3, "R3");

        // R5 status with changing inputs
        stat_in = {16'hD004, 16'hC003, 16'hB002, 16'hA001};
        rd_check(NCFG, "R5");
        rd_check(NCFG+NSTAT-1, "R5");

        // R6 unmapped reads
        rd_check(NCFG+NSTAT, "R6");
        rd_check((1 << AW) - 1, "R6");

        // R7 writes outside configuration range
        cycle(NCFG+1, 1'b0, 1'b1, 16'h1234);
        cycle((1 << AW) - 1, 1'b0, 1'b1, 16'h5678);
        check_cfg("R7");

        // R8 hold, R9 read+write
        rd_check(3, "R3");
        cycle(0, 1'b0, 1'b0, '0);
        check("R8", bus_rdata, last_rd);
        cycle(7, 1'b1, 1'b1, 16'h7777);
        check("R9", bus_rdata, last_rd);
        check_cfg("R9");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int op, a;
            logic [DW-1:0] d;
            op = int'($urandom % 8);
            a = (op < 6) ? int'($urandom % (NCFG + NSTAT + 2)) : int'($urandom % (1 << AW));
            d = DW'($urandom);
            stat_in = {$urandom, $urandom};
            if (op < 3) begin
                cycle(a, 1'b0, 1'b1, d);
                check_cfg(a < NCFG ? "R2" : "R7");
            end else if (op < 6) begin
                rd_check(a, a < NCFG ? "R3" : (a < NCFG + NSTAT ? "R5" : "R6"));
            end else if (op == 6) begin
                cycle(a, 1'b1, 1'b1, d);
                check("R9", bus_rdata, last_rd);
                check_cfg("R9");
            end else begin
                cycle(a, 1'b0, 1'b0, d);
                check("R8", bus_rdata, last_rd);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule